// File: doc/BRIEF.md
# Manchester Line Transmitter with Programmable Preamble

This block turns parallel data words into a single self-clocking serial line. Each bit period is split into two half-bits, and every coded bit has a transition at mid-bit. The direction of that transition carries the bit value. A host offers a word with a valid/ready handshake. When the word is accepted, the block sends a frame made of three parts: an optional preamble, a start bit of value zero, and the data bits least significant bit first. It then returns to idle.

The preamble is set per frame by three inputs. A 4-bit count gives the preamble length in bit periods, and zero removes the preamble. A 2-bit selector picks one of four patterns, each Manchester coded one pattern bit per bit period. A polarity bit swaps the transition direction used for both values, and so inverts the whole coded waveform, preamble included. The half-bit length is set at build time by a clock divider inside the block. All settings and the data word are captured when the frame is accepted.

Top module: `manch_tx`

## Requirements
- R1: While reset is asserted and right after it, `busy` is 0, `tx_ready` is 1 and `line_out` is 1.
- R2: While no frame is in progress, `line_out` equals the inverse of `pol_inv` as sampled at the previous clock edge. This is the level of the first half of a coded one.
- R3: A word is accepted on a clock edge where `tx_valid` and `tx_ready` are both 1. `tx_ready` is 0 for the whole frame, and a `tx_valid` held high during a frame does not disturb it. The held word is accepted on the first edge after the frame ends.
- R4: A frame is sent in this order: `pre_len` preamble bits, then one start bit of value 0, then DATA_W data bits with bit 0 first. Each bit has two halves of HALF_DIV clock cycles each. The first half is driven from the acceptance edge onward, and `line_out` changes only on half-bit boundaries.
- R5: With `pre_len` = 0 there is no preamble, and the frame begins directly with the start bit.
- R6: Preamble bit k (k from 0) depends on `pre_sel`. Code 2'b00 gives 1 for every k. Code 2'b01 gives 0 for every k. Code 2'b10 gives 0 for even k and 1 for odd k. Code 2'b11 gives 1 for even k and 0 for odd k.
- R7: With `pol_inv` = 0, a bit of value 0 is sent as low then high, and a bit of value 1 as high then low.
- R8: With `pol_inv` = 1, every half-bit of the frame, preamble included, is the inverse of its level under `pol_inv` = 0.
- R9: Changes to `tx_data`, `pre_len`, `pre_sel` and `pol_inv` after the acceptance edge have no effect on the frame being sent.
- R10: `busy` stays 1 for exactly 2*(pre_len+1+DATA_W)*HALF_DIV cycles starting at the acceptance edge. It then drops and `tx_ready` returns to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_data | input | DATA_W | Word to transmit |
| tx_valid | input | 1 | Word offered |
| tx_ready | output | 1 | Block can accept a word |
| pre_len | input | PRE_W | Preamble length in bit periods, 0 = none |
| pre_sel | input | 2 | Preamble pattern selector |
| pol_inv | input | 1 | Transition polarity select |
| line_out | output | 1 | Manchester coded serial line |
| busy | output | 1 | Frame in progress |

## Verification
Two events can fall on adjacent edges: the last half-bit of one frame ends, and the next word is accepted. The bench provokes this by keeping `tx_valid` high through a whole frame, with a different word and different settings on the inputs. It then checks every cycle of the first frame against its own waveform model. It also checks that the idle level appears for exactly one cycle and that the second frame starts on the next edge with the new settings. The same run, and a long random run, change all settings while a frame is in progress. This shows that the captured settings alone shape the waveform, while the idle level after the frame follows the live polarity input.

// File: rtl/manch_pkg.sv
package manch_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PRE   = 2'd1,
    ST_START = 2'd2,
    ST_DATA  = 2'd3
  } tx_state_t;

  typedef enum logic [1:0] {
    PAT_ONES  = 2'b00,
    PAT_ZEROS = 2'b01,
    PAT_ZO    = 2'b10,
    PAT_OZ    = 2'b11
  } pre_pat_t;

  // Line level for one half of a coded bit. First half carries the bit,
  // second half its complement; the polarity bit flips both.
  function automatic logic half_level(input logic bit_val,
                                      input logic second_half,
                                      input logic inv);
    return bit_val ^ second_half ^ inv;
  endfunction

endpackage

// File: rtl/manch_half_timer.sv
module manch_half_timer #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic half_tick
);

  generate
    if (HALF_DIV <= 1) begin : g_nodiv
      logic unused_in;
      assign unused_in = clk ^ rst_n ^ restart;
      assign half_tick = run;
    end else begin : g_div
      localparam int CW = $clog2(HALF_DIV);
      localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

      logic [CW-1:0] cnt_q;
      logic [CW-1:0] cnt_d;

      always_comb begin
        cnt_d = cnt_q;
        if (restart) begin
          cnt_d = '0;
        end else if (run) begin
          cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_d;
        end
      end

      assign half_tick = run && (cnt_q == LAST);
    end
  endgenerate

endmodule

// File: rtl/manch_pre_pattern.sv
module manch_pre_pattern
  import manch_pkg::*;
(
  input  logic [1:0] pat,
  input  logic       odd_idx,
  output logic       pat_bit
);

  always_comb begin
    case (pre_pat_t'(pat))
      PAT_ONES:  pat_bit = 1'b1;
      PAT_ZEROS: pat_bit = 1'b0;
      PAT_ZO:    pat_bit = odd_idx;
      PAT_OZ:    pat_bit = ~odd_idx;
      default:   pat_bit = 1'b0;
    endcase
  end

endmodule

// File: rtl/manch_frame_seq.sv
module manch_frame_seq
  import manch_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PRE_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [DATA_W-1:0] in_data,
  input  logic [PRE_W-1:0]  in_plen,
  input  logic [1:0]        in_pat,
  input  logic              in_pol,
  input  logic              half_tick,
  output logic              busy,
  output logic              line
);

  localparam int DW_LOG = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int CNT_W  = (PRE_W > DW_LOG) ? PRE_W : DW_LOG;
  localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(DATA_W - 1);

  tx_state_t         st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              half_q, half_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic [PRE_W-1:0]  plen_q, plen_d;
  logic [1:0]        pat_q, pat_d;
  logic              pol_q, pol_d;
  logic              line_q, line_d;

  logic [1:0]        pre_par;
  logic              pre_first;
  logic              pre_cur;
  logic              pre_nxt;
  logic              cur_bit;
  logic              nxt_bit;
  logic [CNT_W-1:0]  plen_last;

  // Pattern bit for even and odd preamble positions of the captured pattern
  generate
    for (genvar p = 0; p < 2; p++) begin : g_par
      manch_pre_pattern u_pat (
        .pat     (pat_q),
        .odd_idx (1'(p)),
        .pat_bit (pre_par[p])
      );
    end
  endgenerate

  // First preamble bit from the live inputs, used on the acceptance edge
  manch_pre_pattern u_pat_first (
    .pat     (in_pat),
    .odd_idx (1'b0),
    .pat_bit (pre_first)
  );

  assign pre_cur   = pre_par[cnt_q[0]];
  assign pre_nxt   = pre_par[~cnt_q[0]];
  assign plen_last = CNT_W'(plen_q) - CNT_W'(1);

  always_comb begin
    case (st_q)
      ST_PRE:  cur_bit = pre_cur;
      ST_DATA: cur_bit = sh_q[0];
      default: cur_bit = 1'b0;
    endcase
  end

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    half_d  = half_q;
    sh_d    = sh_q;
    plen_d  = plen_q;
    pat_d   = pat_q;
    pol_d   = pol_q;
    line_d  = line_q;
    nxt_bit = 1'b0;

    if (st_q == ST_IDLE) begin
      line_d = ~in_pol;
      if (accept) begin
        plen_d = in_plen;
        pat_d  = in_pat;
        pol_d  = in_pol;
        sh_d   = in_data;
        cnt_d  = '0;
        half_d = 1'b0;
        if (in_plen != '0) begin
          st_d   = ST_PRE;
          line_d = half_level(pre_first, 1'b0, in_pol);
        end else begin
          st_d   = ST_START;
          line_d = half_level(1'b0, 1'b0, in_pol);
        end
      end
    end else if (half_tick) begin
      if (!half_q) begin
        half_d = 1'b1;
        line_d = half_level(cur_bit, 1'b1, pol_q);
      end else begin
        half_d = 1'b0;
        case (st_q)
          ST_PRE: begin
            if (cnt_q == plen_last) begin
              st_d    = ST_START;
              cnt_d   = '0;
              nxt_bit = 1'b0;
            end else begin
              cnt_d   = cnt_q + 1'b1;
              nxt_bit = pre_nxt;
            end
          end
          ST_START: begin
            st_d    = ST_DATA;
            cnt_d   = '0;
            nxt_bit = sh_q[0];
          end
          default: begin
            sh_d = sh_q >> 1;
            if (cnt_q == LAST_DATA) begin
              st_d = ST_IDLE;
            end else begin
              cnt_d   = cnt_q + 1'b1;
              nxt_bit = sh_q[1];
            end
          end
        endcase
        line_d = (st_d == ST_IDLE) ? ~in_pol : half_level(nxt_bit, 1'b0, pol_q);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      half_q <= 1'b0;
      sh_q   <= '0;
      plen_q <= '0;
      pat_q  <= '0;
      pol_q  <= 1'b0;
      line_q <= 1'b1;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      half_q <= half_d;
      sh_q   <= sh_d;
      plen_q <= plen_d;
      pat_q  <= pat_d;
      pol_q  <= pol_d;
      line_q <= line_d;
    end
  end

  assign busy = (st_q != ST_IDLE);
  assign line = line_q;

endmodule

// File: rtl/manch_tx.sv
module manch_tx #(
  parameter int DATA_W   = 8,
  parameter int PRE_W    = 4,
  parameter int HALF_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [PRE_W-1:0]  pre_len,
  input  logic [1:0]        pre_sel,
  input  logic              pol_inv,
  output logic              line_out,
  output logic              busy
);

  logic accept;
  logic half_tick;
  logic busy_int;

  assign tx_ready = ~busy_int;
  assign accept   = tx_valid & ~busy_int;
  assign busy     = busy_int;

  manch_half_timer #(
    .HALF_DIV (HALF_DIV)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (busy_int),
    .restart   (accept),
    .half_tick (half_tick)
  );

  manch_frame_seq #(
    .DATA_W (DATA_W),
    .PRE_W  (PRE_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .in_data   (tx_data),
    .in_plen   (pre_len),
    .in_pat    (pre_sel),
    .in_pol    (pol_inv),
    .half_tick (half_tick),
    .busy      (busy_int),
    .line      (line_out)
  );

endmodule

// File: rtl/manch_tx_checker.sv
module manch_tx_checker #(
  parameter int DATA_W   = 8,
  parameter int PRE_W    = 4,
  parameter int HALF_DIV = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic [PRE_W-1:0] pre_len,
  input logic             pol_inv,
  input logic             line_out,
  input logic             busy
);

  logic [15:0] cyc_q;
  logic [15:0] len_q;
  logic        armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q   <= '0;
      len_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      armed_q <= 1'b1;
      if (tx_valid && tx_ready) begin
        cyc_q <= '0;
        len_q <= 16'((32'(pre_len) + 1 + DATA_W) * 2 * HALF_DIV);
      end else if (busy) begin
        cyc_q <= cyc_q + 16'd1;
      end else begin
        cyc_q <= '0;
      end
    end
  end

  assert_accept_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> busy);

  assert_no_ready_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !tx_ready);

  assert_half_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(line_out)) |-> ((32'(cyc_q) % HALF_DIV) == 0));

  assert_within_len_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cyc_q < len_q));

  assert_frame_len_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(cyc_q) == len_q - 16'd1));

  assert_idle_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !busy && !$past(busy)) |-> (line_out == !$past(pol_inv)));

endmodule

bind manch_tx manch_tx_checker #(
  .DATA_W   (DATA_W),
  .PRE_W    (PRE_W),
  .HALF_DIV (HALF_DIV)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tx_valid (tx_valid),
  .tx_ready (tx_ready),
  .pre_len  (pre_len),
  .pol_inv  (pol_inv),
  .line_out (line_out),
  .busy     (busy)
);

// File: tb/manch_tx_bench.sv
`timescale 1ns/1ps
module manch_tx_bench;

  localparam int DW = 8;
  localparam int PW = 4;
  localparam int HD = 4;

  logic          clk;
  logic          rst_n;
  logic [DW-1:0] tx_data;
  logic          tx_valid;
  logic          tx_ready;
  logic [PW-1:0] pre_len;
  logic [1:0]    pre_sel;
  logic          pol_inv;
  logic          line_out;
  logic          busy;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  manch_tx #(.DATA_W(DW), .PRE_W(PW), .HALF_DIV(HD)) u_manch_tx (
    .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .pre_len(pre_len), .pre_sel(pre_sel),
    .pol_inv(pol_inv), .line_out(line_out), .busy(busy)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic pre_bit(input logic [1:0] pat, input int k);
    case (pat)
      2'b00:   return 1'b1;
      2'b01:   return 1'b0;
      2'b10:   return k[0];
      default: return ~k[0];
    endcase
  endfunction

  function automatic logic exp_line(input logic [DW-1:0] d, input int plen,
                                    input logic [1:0] pat, input logic pol, input int h);
    int   b;
    logic v;
    b = h / 2;
    if (b < plen)       v = pre_bit(pat, b);
    else if (b == plen) v = 1'b0;
    else                v = d[b - plen - 1];
    return v ^ logic'(h % 2) ^ pol;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic start_frame(input logic [DW-1:0] d, input int plen,
                             input logic [1:0] pat, input logic pol);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_data  = d;
    pre_len  = PW'(plen);
    pre_sel  = pat;
    pol_inv  = pol;
    tx_valid = 1'b1;
    @(posedge clk);
  endtask

  // Starts right after the acceptance edge; ends at the first idle negedge.
  task automatic check_frame(input logic [DW-1:0] d, input int plen,
                             input logic [1:0] pat, input logic pol,
                             input bit scramble, input bit keep_valid, input string req);
    int   len;
    int   bad;
    int   first_c;
    logic e;
    len = 2 * (plen + 1 + DW) * HD;
    bad = 0;
    first_c = -1;
    @(negedge clk);
    if (!keep_valid) tx_valid = 1'b0;
    if (scramble) begin
      tx_data = DW'($urandom);
      pre_len = PW'($urandom);
      pre_sel = 2'($urandom);
      pol_inv = 1'($urandom);
    end
    for (int c = 0; c < len; c++) begin
      e = exp_line(d, plen, pat, pol, c / HD);
      if (line_out !== e || busy !== 1'b1 || tx_ready !== 1'b0) begin
        if (bad == 0) first_c = c;
        bad++;
      end
      @(negedge clk);
    end
    if (bad != 0) $display("  first mismatching cycle %0d of %0d", first_c, len);
    check(bad == 0, req, "cycles off expected waveform", bad, 0);
    check(busy == 1'b0 && tx_ready == 1'b1, "R10", "busy/ready after frame",
          {30'd0, busy, tx_ready}, 1);
    check(line_out == ~pol_inv, "R2", "idle level after frame", line_out, ~pol_inv);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL R10 watchdog actual=expired expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d2;
    int            p2;
    logic [1:0]    s2;
    logic          o2;
    void'($urandom(32'd4242));
    rst_n    = 1'b0;
    tx_valid = 1'b0;
    tx_data  = '0;
    pre_len  = '0;
    pre_sel  = 2'b00;
    pol_inv  = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(line_out == 1'b1, "R1", "line in reset", line_out, 1);
    check(busy == 1'b0 && tx_ready == 1'b1, "R1", "busy/ready in reset",
          {30'd0, busy, tx_ready}, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(line_out == 1'b0, "R2", "idle level pol=1", line_out, 0);
    pol_inv = 1'b0;
    @(negedge clk);
    check(line_out == 1'b1, "R2", "idle level pol=0", line_out, 1);

    // Directed corner cases
    start_frame(8'h00, 0, 2'b00, 1'b0);  check_frame(8'h00, 0, 2'b00, 1'b0, 0, 0, "R5");
    start_frame(8'h01, 0, 2'b00, 1'b0);  check_frame(8'h01, 0, 2'b00, 1'b0, 0, 0, "R7");
    start_frame(8'hFF, 0, 2'b00, 1'b1);  check_frame(8'hFF, 0, 2'b00, 1'b1, 0, 0, "R8");
    start_frame(8'hA5, 15, 2'b00, 1'b0); check_frame(8'hA5, 15, 2'b00, 1'b0, 0, 0, "R6");
    start_frame(8'h5A, 15, 2'b01, 1'b0); check_frame(8'h5A, 15, 2'b01, 1'b0, 0, 0, "R6");
    start_frame(8'h3C, 7, 2'b10, 1'b0);  check_frame(8'h3C, 7, 2'b10, 1'b0, 0, 0, "R6");
    start_frame(8'hC3, 6, 2'b11, 1'b1);  check_frame(8'hC3, 6, 2'b11, 1'b1, 0, 0, "R8");
    start_frame(8'h96, 1, 2'b10, 1'b0);  check_frame(8'h96, 1, 2'b10, 1'b0, 0, 0, "R4");

    // Back-to-back: valid held through a frame, next word taken at once
    start_frame(8'h81, 3, 2'b11, 1'b0);
    check_frame(8'h81, 3, 2'b11, 1'b0, 1, 1, "R3");
    d2 = tx_data; p2 = int'(pre_len); s2 = pre_sel; o2 = pol_inv;
    @(posedge clk);
    check_frame(d2, p2, s2, o2, 1, 0, "R3");

    // Random frames with settings changed mid-frame
    for (int i = 0; i < 25; i++) begin
      d2 = DW'($urandom);
      p2 = int'($urandom % 16);
      s2 = 2'($urandom);
      o2 = 1'($urandom);
      start_frame(d2, p2, s2, o2);
      check_frame(d2, p2, s2, o2, 1, 0, "R9");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule